// File: doc/BRIEF.md
# Mailbox Command Issuer

This block sends a single command to an embedded controller through a small set of shared mailbox registers and returns a 32-bit result code. A client pulses `start` with a function number, a version, three argument words and a 31-bit command code. The block then works through the whole exchange on its own register-bus master port and reports the outcome with a one-cycle `done` pulse.

The exchange has four stages. First the block takes a hardware semaphore: it reads a lock register until that register returns 1. It then fills the mailbox and polls the command/response register on a fixed interval until the controller answers. Last, it releases the semaphore by reading an unlock register. Both waiting loops are bounded by a retry limit. If either loop runs out of attempts, the result is a dedicated timeout code. When the controller reports a failure, the block fetches the controller's error code from the first argument register and returns it as the result.

Top module: `mbox_cmd_issuer`

## Requirements
- R1: After an accepted `start`, the first bus access is a read of `LOCK_ADDR`. The block continues only when that read returns exactly 1. Any other value causes a wait of at least `POLL_CYCLES` cycles, and then the lock is read again.
- R2: If `RETRY_LIMIT` lock reads in a row fail, the block finishes with result `RC_TIMEOUT`. In that case it makes no mailbox write and no unlock read.
- R3: Once the lock is held, the mailbox is written in this order: `SIGN_ADDR`, `ARG1_ADDR`, `ARG2_ADDR`, `ARG3_ADDR`, then `CMD_ADDR`. The signature word carries the function number in bits [7:0] and the version in bits [15:8], with zeros above.
- R4: The word written to `CMD_ADDR` has bit 31 set to 1 and the command code in bits [30:0].
- R5: Every read of `CMD_ADDR` comes at least `POLL_CYCLES` cycles after the preceding command write or response read. A value with bit 31 set is not a response, and polling continues.
- R6: If the response value is 1 (OK), or any other value with bit 31 clear that is not 2 or 3, the result is 0.
- R7: If the response value is 2 (failure), the block reads `ARG1_ADDR` and returns that value as the result.
- R8: If `RETRY_LIMIT` response reads all show bit 31 set, or if the response value is 3, the result is `RC_TIMEOUT`.
- R9: Every command that acquired the lock ends with exactly one read of `UNLOCK_ADDR`. This read is the last bus access of the command.
- R10: `done` is high for exactly one cycle and presents the result on that cycle. A `start` seen while `busy` is high has no effect, and the bus is idle whenever `busy` is low.
- R11: Once `bus_valid` is raised, it stays high with the same address, direction and write data until `bus_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a command (ignored while busy) |
| func_num | input | 8 | Function number placed in the signature |
| version | input | 8 | Interface version placed in the signature |
| arg1 | input | 32 | First argument word |
| arg2 | input | 32 | Second argument word |
| arg3 | input | 32 | Third argument word |
| cmd_code | input | 31 | Command code |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Result code, valid with done |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus request accepted |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Register address |
| bus_wdata | output | 32 | Write data |
| bus_rvalid | input | 1 | Read data valid |
| bus_rdata | input | 32 | Read data |

## Verification
The assertions check four properties on every cycle:
- a bus request is held stable while it is stalled;
- a command write always carries bit 31;
- `done` never lasts longer than a single cycle;
- the bus stays quiet whenever the block is idle.

The remaining behaviour depends on what the controller returns, so only the bench's scenarios can show it. That includes the order of the mailbox writes, the spacing between retries, the exact number of attempts before either timeout, the error-code fetch after a failure, and whether an unlock read happens. The bench covers each of these through the transaction log of a modelled controller.

// File: rtl/mbox_cmd_issuer.sv
module mbox_cmd_issuer #(
  parameter int          AW          = 12,
  parameter int          POLL_CYCLES = 50000,
  parameter int          RETRY_LIMIT = 4000,
  parameter logic [31:0] RC_TIMEOUT  = 32'hFFFF_FFFF,
  parameter logic [AW-1:0] LOCK_ADDR   = 'h010,
  parameter logic [AW-1:0] UNLOCK_ADDR = 'h014,
  parameter logic [AW-1:0] SIGN_ADDR   = 'h020,
  parameter logic [AW-1:0] ARG1_ADDR   = 'h024,
  parameter logic [AW-1:0] ARG2_ADDR   = 'h028,
  parameter logic [AW-1:0] ARG3_ADDR   = 'h02C,
  parameter logic [AW-1:0] CMD_ADDR    = 'h030
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    func_num,
  input  logic [7:0]    version,
  input  logic [31:0]   arg1,
  input  logic [31:0]   arg2,
  input  logic [31:0]   arg3,
  input  logic [30:0]   cmd_code,
  output logic          busy,
  output logic          done,
  output logic [31:0]   result,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [31:0]   bus_wdata,
  input  logic          bus_rvalid,
  input  logic [31:0]   bus_rdata
);

  localparam int DLY_W = $clog2(POLL_CYCLES + 1);
  localparam int TRY_W = $clog2(RETRY_LIMIT + 2);
  localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(POLL_CYCLES - 1);
  localparam logic [TRY_W-1:0] TRY_MAX  = TRY_W'(RETRY_LIMIT);
  localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(RETRY_LIMIT - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_LK_RD, S_LK_WT, S_LK_DLY, S_WR, S_PL_DLY, S_PL_RD,
    S_PL_WT, S_ER_RD, S_ER_WT, S_UL_RD, S_UL_WT
  } st_t;

  st_t              st;
  logic [2:0]       widx;
  logic [DLY_W-1:0] dly;
  logic [TRY_W-1:0] tries;
  logic [7:0]       func_q, ver_q;
  logic [31:0]      a1_q, a2_q, a3_q, res_q;
  logic [30:0]      cmd_q;
  logic             done_q;
  logic             fire;

  assign busy   = (st != S_IDLE);
  assign done   = done_q;
  assign result = res_q;
  assign fire   = bus_valid & bus_ready;

  always_comb begin
    bus_valid = 1'b0;
    bus_write = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (st)
      S_LK_RD: begin bus_valid = 1'b1; bus_addr = LOCK_ADDR; end
      S_PL_RD: begin bus_valid = 1'b1; bus_addr = CMD_ADDR; end
      S_ER_RD: begin bus_valid = 1'b1; bus_addr = ARG1_ADDR; end
      S_UL_RD: begin bus_valid = 1'b1; bus_addr = UNLOCK_ADDR; end
      S_WR: begin
        bus_valid = 1'b1;
        bus_write = 1'b1;
        case (widx)
          3'd0:    begin bus_addr = SIGN_ADDR; bus_wdata = {16'h0000, ver_q, func_q}; end
          3'd1:    begin bus_addr = ARG1_ADDR; bus_wdata = a1_q; end
          3'd2:    begin bus_addr = ARG2_ADDR; bus_wdata = a2_q; end
          3'd3:    begin bus_addr = ARG3_ADDR; bus_wdata = a3_q; end
          default: begin bus_addr = CMD_ADDR;  bus_wdata = {1'b1, cmd_q}; end
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      widx   <= '0;
      dly    <= '0;
      tries  <= '0;
      func_q <= '0;
      ver_q  <= '0;
      a1_q   <= '0;
      a2_q   <= '0;
      a3_q   <= '0;
      cmd_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          func_q <= func_num;
          ver_q  <= version;
          a1_q   <= arg1;
          a2_q   <= arg2;
          a3_q   <= arg3;
          cmd_q  <= cmd_code;
          tries  <= '0;
          st     <= S_LK_RD;
        end
        S_LK_RD: if (fire) st <= S_LK_WT;
        S_LK_WT: if (bus_rvalid) begin
          if (bus_rdata == 32'd1) begin
            widx <= '0;
            st   <= S_WR;
          end else if (tries == TRY_LAST) begin
            res_q  <= RC_TIMEOUT;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end else begin
            tries <= tries + 1'b1;
            dly   <= DLY_LOAD;
            st    <= S_LK_DLY;
          end
        end
        S_LK_DLY: if (dly == '0) st <= S_LK_RD; else dly <= dly - 1'b1;
        S_WR: if (fire) begin
          if (widx == 3'd4) begin
            tries <= '0;
            dly   <= DLY_LOAD;
            st    <= S_PL_DLY;
          end else begin
            widx <= widx + 1'b1;
          end
        end
        S_PL_DLY: if (dly == '0) begin
          if (tries == TRY_MAX) begin
            res_q <= RC_TIMEOUT;
            st    <= S_UL_RD;
          end else begin
            tries <= tries + 1'b1;
            st    <= S_PL_RD;
          end
        end else begin
          dly <= dly - 1'b1;
        end
        S_PL_RD: if (fire) st <= S_PL_WT;
        S_PL_WT: if (bus_rvalid) begin
          if (bus_rdata[31]) begin
            dly <= DLY_LOAD;
            st  <= S_PL_DLY;
          end else if (bus_rdata == 32'd2) begin
            st <= S_ER_RD;
          end else begin
            res_q <= (bus_rdata == 32'd3) ? RC_TIMEOUT : 32'd0;
            st    <= S_UL_RD;
          end
        end
        S_ER_RD: if (fire) st <= S_ER_WT;
        S_ER_WT: if (bus_rvalid) begin
          res_q <= bus_rdata;
          st    <= S_UL_RD;
        end
        S_UL_RD: if (fire) st <= S_UL_WT;
        S_UL_WT: if (bus_rvalid) begin
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) &&
    $stable(bus_write) && $stable(bus_wdata));

  // R4
  cmd_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_addr == CMD_ADDR |-> bus_wdata[31]);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_valid);

endmodule

// File: tb/mbox_cmd_issuer_bench.sv
`timescale 1ns/1ps
module mbox_cmd_issuer_bench;
  localparam int PC  = 3;
  localparam int RL  = 5;
  localparam logic [31:0] TMO = 32'hFFFF_FFFF;
  localparam logic [11:0] A_LOCK = 12'h010, A_UNL = 12'h014, A_SIGN = 12'h020,
                          A_ARG1 = 12'h024, A_ARG2 = 12'h028, A_ARG3 = 12'h02C,
                          A_CMD = 12'h030;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] func_num = '0, version = '0;
  logic [31:0] arg1 = '0, arg2 = '0, arg3 = '0;
  logic [30:0] cmd_code = '0;
  logic busy, done, bus_valid, bus_write, bus_ready;
  logic [31:0] result, bus_wdata;
  logic [11:0] bus_addr;
  logic bus_rvalid = 1'b0;
  logic [31:0] bus_rdata = '0;

  int cfg_lock_zeros = 0, cfg_busy_polls = 0;
  logic [31:0] cfg_rsp = 32'd1, cfg_err = 32'd0;
  logic stall_en = 1'b0;

  int cyc = 0, lk_cnt = 0, pl_cnt = 0, done_cnt = 0, lg_n = 0;
  logic [11:0] lg_addr [64];
  logic        lg_we   [64];
  logic [31:0] lg_data [64];
  int          lg_cyc  [64];

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] res_got;

  always #10 clk = ~clk;

  assign bus_ready = !stall_en || cyc[0];

  mbox_cmd_issuer #(.AW(12), .POLL_CYCLES(PC), .RETRY_LIMIT(RL), .RC_TIMEOUT(TMO),
    .LOCK_ADDR(A_LOCK), .UNLOCK_ADDR(A_UNL), .SIGN_ADDR(A_SIGN), .ARG1_ADDR(A_ARG1),
    .ARG2_ADDR(A_ARG2), .ARG3_ADDR(A_ARG3), .CMD_ADDR(A_CMD)) u_mbox_cmd_issuer (
    .clk(clk), .rst_n(rst_n), .start(start), .func_num(func_num), .version(version),
    .arg1(arg1), .arg2(arg2), .arg3(arg3), .cmd_code(cmd_code), .busy(busy),
    .done(done), .result(result), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    bus_rvalid <= 1'b0;
    if (done) done_cnt <= done_cnt + 1;
    if (rst_n && start && !busy) begin
      lg_n <= 0; lk_cnt <= 0; pl_cnt <= 0; done_cnt <= 0;
    end else if (rst_n && bus_valid && bus_ready) begin
      if (lg_n < 64) begin
        lg_addr[lg_n] <= bus_addr;
        lg_we[lg_n]   <= bus_write;
        lg_data[lg_n] <= bus_wdata;
        lg_cyc[lg_n]  <= cyc;
      end
      lg_n <= lg_n + 1;
      if (!bus_write) begin
        bus_rvalid <= 1'b1;
        if (bus_addr == A_LOCK) begin
          bus_rdata <= (lk_cnt < cfg_lock_zeros) ? 32'd0 : 32'd1;
          lk_cnt <= lk_cnt + 1;
        end else if (bus_addr == A_CMD) begin
          bus_rdata <= (pl_cnt < cfg_busy_polls) ? 32'h8000_0012 : cfg_rsp;
          pl_cnt <= pl_cnt + 1;
        end else if (bus_addr == A_ARG1) bus_rdata <= cfg_err;
        else bus_rdata <= 32'd0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic setup(input int lz, input int bp, input logic [31:0] rsp, input logic [31:0] err);
    cfg_lock_zeros = lz; cfg_busy_polls = bp; cfg_rsp = rsp; cfg_err = err;
  endtask

  task automatic launch(input logic [7:0] f, input logic [7:0] v, input logic [30:0] c);
    @(negedge clk);
    func_num = f; version = v; cmd_code = c;
    arg1 = 32'h1111_0001; arg2 = 32'h2222_0002; arg3 = 32'h3333_0003;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done;
    for (int i = 0; i < 3000; i++) begin
      if (done) break;
      @(negedge clk);
    end
    res_got = result;
    check(done === 1'b1, "R10 done seen", {31'd0, done}, 32'd1);
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset;
    check(busy === 1'b0, "R10 reset busy", {31'd0, busy}, 32'd0);
    check(done === 1'b0, "R10 reset done", {31'd0, done}, 32'd0);
    check(bus_valid === 1'b0, "R10 reset bus idle", {31'd0, bus_valid}, 32'd0);
  endtask

  task automatic t_ok;
    stall_en = 1'b1;
    setup(0, 2, 32'd1, 32'd0);
    launch(8'h05, 8'h01, 31'h12);
    wait_done();
    check(res_got === 32'd0, "R6 ok result", res_got, 32'd0);
    check(lg_n == 10, "R9 ok access count", lg_n, 10);
    check(lg_addr[0] == A_LOCK && !lg_we[0], "R1 first access lock read", {20'd0, lg_addr[0]}, {20'd0, A_LOCK});
    check(lg_addr[1] == A_SIGN && lg_we[1] && lg_data[1] == 32'h0000_0105, "R3 signature", lg_data[1], 32'h0000_0105);
    check(lg_addr[2] == A_ARG1 && lg_data[2] == 32'h1111_0001, "R3 arg1 write", {20'd0, lg_addr[2]}, {20'd0, A_ARG1});
    check(lg_addr[3] == A_ARG2 && lg_data[3] == 32'h2222_0002, "R3 arg2 write", {20'd0, lg_addr[3]}, {20'd0, A_ARG2});
    check(lg_addr[4] == A_ARG3 && lg_data[4] == 32'h3333_0003, "R3 arg3 write", {20'd0, lg_addr[4]}, {20'd0, A_ARG3});
    check(lg_addr[5] == A_CMD && lg_we[5] && lg_data[5] == 32'h8000_0012, "R4 command word", lg_data[5], 32'h8000_0012);
    check(lg_addr[6] == A_CMD && lg_addr[8] == A_CMD && !lg_we[8], "R5 three polls", {20'd0, lg_addr[8]}, {20'd0, A_CMD});
    check(lg_cyc[6] - lg_cyc[5] >= PC, "R5 first poll spacing", lg_cyc[6] - lg_cyc[5], PC);
    check(lg_cyc[7] - lg_cyc[6] >= PC, "R5 repoll spacing", lg_cyc[7] - lg_cyc[6], PC);
    check(lg_addr[9] == A_UNL && !lg_we[9], "R9 unlock last", {20'd0, lg_addr[9]}, {20'd0, A_UNL});
    check(done_cnt == 1, "R10 single done", done_cnt, 1);
    stall_en = 1'b0;
  endtask

  task automatic t_fail;
    setup(0, 0, 32'd2, 32'h0000_ABCD);
    launch(8'h02, 8'h01, 31'h07);
    wait_done();
    check(res_got === 32'h0000_ABCD, "R7 error code result", res_got, 32'h0000_ABCD);
    check(lg_n == 9 && lg_addr[7] == A_ARG1 && !lg_we[7], "R7 arg1 read back", {20'd0, lg_addr[7]}, {20'd0, A_ARG1});
    check(lg_addr[8] == A_UNL, "R9 unlock after failure", {20'd0, lg_addr[8]}, {20'd0, A_UNL});
  endtask

  task automatic t_lock_retry;
    setup(2, 0, 32'd1, 32'd0);
    launch(8'h03, 8'h01, 31'h09);
    wait_done();
    check(lg_addr[0] == A_LOCK && lg_addr[1] == A_LOCK && lg_addr[2] == A_LOCK, "R1 lock retries", {20'd0, lg_addr[2]}, {20'd0, A_LOCK});
    check(lg_addr[3] == A_SIGN && lg_we[3], "R1 proceed after lock", {20'd0, lg_addr[3]}, {20'd0, A_SIGN});
    check(lg_cyc[1] - lg_cyc[0] >= PC, "R1 lock retry spacing", lg_cyc[1] - lg_cyc[0], PC);
    check(res_got === 32'd0 && lg_n == 10, "R6 result after lock retry", res_got, 32'd0);
  endtask

  task automatic t_lock_tmo;
    bit all_lock;
    setup(100, 0, 32'd1, 32'd0);
    launch(8'h01, 8'h01, 31'h0A);
    wait_done();
    all_lock = 1;
    for (int i = 0; i < RL; i++) if (lg_addr[i] != A_LOCK || lg_we[i]) all_lock = 0;
    check(res_got === TMO, "R2 lock timeout result", res_got, TMO);
    check(lg_n == RL, "R2 lock attempt count", lg_n, RL);
    check(all_lock, "R2 no mailbox or unlock access", {31'd0, all_lock}, 32'd1);
  endtask

  task automatic t_rsp_tmo;
    setup(0, 100, 32'd1, 32'd0);
    launch(8'h01, 8'h01, 31'h0F);
    wait_done();
    check(res_got === TMO, "R8 response timeout result", res_got, TMO);
    check(lg_n == 6 + RL + 1, "R8 poll attempt count", lg_n, 6 + RL + 1);
    check(lg_addr[6 + RL] == A_UNL, "R9 unlock after timeout", {20'd0, lg_addr[6 + RL]}, {20'd0, A_UNL});
  endtask

  task automatic t_rsp3;
    setup(0, 1, 32'd3, 32'd0);
    launch(8'h01, 8'h01, 31'h10);
    wait_done();
    check(res_got === TMO, "R8 timeout response code", res_got, TMO);
    check(lg_n == 9 && lg_addr[8] == A_UNL, "R9 unlock after code 3", lg_n, 9);
  endtask

  task automatic t_busy_start;
    setup(0, 3, 32'd1, 32'd0);
    launch(8'h0A, 8'h02, 31'h01);
    repeat (4) @(negedge clk);
    func_num = 8'h77; version = 8'h66; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (20) @(negedge clk);
    check(lg_data[1] == 32'h0000_020A, "R10 start while busy ignored", lg_data[1], 32'h0000_020A);
    check(done_cnt == 1 && lg_n == 11, "R10 one command only", done_cnt, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_ok();
    t_fail();
    t_lock_retry();
    t_lock_tmo();
    t_rsp_tmo();
    t_rsp3();
    t_busy_start();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule